// File: doc/BRIEF.md
# T1 Line Performance Error Counters

This block collects the per-interval performance counts of a T1 receive path. Three event streams enter as single-cycle pulses, each valid for one clock: line code violations (a bipolar violation or an excessive-zeros event), CRC6 or framing-bit errors, and receive multiframes spent out of synchronization. The line decoder, the B8ZS decoder and the framer that produce these pulses are outside the block. Each stream feeds a running saturating counter. An interval timer counts a 1.544 MHz reference enable. At every interval boundary the timer copies the three running totals into holding registers and restarts the running counts.

A host reads the holding registers over a small byte-wide register bus. Because the holding registers change only at boundaries, a value the host reads always covers one whole completed interval. The host has until the next boundary to collect it. A control register selects a long interval (one second of reference ticks) or a short one (42 ms). The same register turns on removal of B8ZS substitution codewords from the violation count and enables the interval interrupt. A status flag marks each boundary and is cleared when it is read.

The reference tick counts per interval are parameters. The one-second default is 1 544 000 ticks and the 42 ms default is 64 848 ticks, so a testbench can shorten both intervals.

Top module: `t1_perf_counters`

## Requirements
- R1: The violation counter adds one for each cycle in which `ev_bpv` or `ev_exz` is high. When control bit 1 (B8ZS removal) is 1, a cycle with `ev_b8zs_cw` high adds nothing. When control bit 1 is 0, `ev_b8zs_cw` has no effect.
- R2: `rx_los` has no effect on any count. The violation counter keeps counting while it is high.
- R3: The CRC/framing counter adds one for `ev_crc` and one for `ev_fbit`. When both are high in the same cycle, it adds two.
- R4: The out-of-sync counter adds one for each cycle in which `ev_mf_oos` is high.
- R5: An interval ends on a `ref_tick` cycle. An interval lasts `REF_PER_LONG` ticks when control bit 0 is 0 and `REF_PER_SHORT` ticks when control bit 0 is 1.
- R6: At an interval end, each holding register takes the running total of the interval that just ended. Each holding register then stays unchanged until the next interval end.
- R7: An event in the same cycle as an interval end is counted in the new interval. It is not counted in the old interval, is not lost, and is not counted twice.
- R8: The counters saturate and never wrap. The violation counter stops at 65535, the CRC/framing counter at 4095 and the out-of-sync counter at 255.
- R9: The register map is as follows; every other address reads 0.
  - 0x20: status, with the interval flag in bit 0.
  - 0x21: control, with bits [2:0] readable and writable.
  - 0x23: violation count [15:8].
  - 0x24: violation count [7:0].
  - 0x25: CRC/framing count [11:8] in bits [3:0].
  - 0x26: CRC/framing count [7:0].
  - 0x27: out-of-sync count.
- R10: The status flag is set by an interval end. A read strobe at 0x20 clears the flag, unless an interval end happens in the same cycle; in that case the flag stays set.
- R11: `irq` is high exactly when the status flag is 1 and control bit 2 is 1.
- R12: After reset, all counts, the control register and the flag are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle enable at the 1.544 MHz reference rate |
| ev_bpv | input | 1 | Bipolar violation seen this cycle |
| ev_exz | input | 1 | Excessive-zeros event this cycle |
| ev_b8zs_cw | input | 1 | The current violation belongs to a valid B8ZS substitution codeword |
| rx_los | input | 1 | Receive loss of synchronization (does not gate counting) |
| ev_crc | input | 1 | CRC6 error this cycle |
| ev_fbit | input | 1 | Framing-bit error this cycle |
| ev_mf_oos | input | 1 | One multiframe spent out of sync |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe (read side effects) |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interval interrupt |

## Verification
The holding registers, the timer and the status flag are registered state, so faults in them show at the ports with little delay.
- A running counter that wraps instead of saturating, or that loses the event of a boundary cycle, leaves a wrong value in a holding register. The host reads that value one interval after the fault, at the first boundary that follows.
- A holding register that follows the running count mid-interval shows up on a second read taken before the next boundary.
- A wrong timer limit shifts the `irq` rising edge by at least one cycle in the very first interval.
- A flag that is not cleared, or not set, shows on `irq` or on the status read one cycle after the strobe or the boundary.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

  localparam logic [7:0] A_STATUS = 8'h20;
  localparam logic [7:0] A_CTRL   = 8'h21;
  localparam logic [7:0] A_CV_HI  = 8'h23;
  localparam logic [7:0] A_CV_LO  = 8'h24;
  localparam logic [7:0] A_FE_HI  = 8'h25;
  localparam logic [7:0] A_FE_LO  = 8'h26;
  localparam logic [7:0] A_OOS    = 8'h27;

  typedef struct packed {
    logic tick_en;
    logic b8zs_rm;
    logic short_sel;
  } ctrl_t;

  // Adds inc to v and clamps the sum at maxv.
  function automatic logic [31:0] sat_add(input logic [31:0] v,
                                          input logic [31:0] inc,
                                          input logic [31:0] maxv);
    logic [32:0] s;
    s = {1'b0, v} + {1'b0, inc};
    if (s > {1'b0, maxv}) return maxv;
    return s[31:0];
  endfunction

  // Returns 1 when a cycle holds a violation that must be counted.
  function automatic logic viol_hit(input logic bpv, input logic exz,
                                    input logic cw, input logic rm_en);
    return (bpv | exz) & ~(rm_en & cw);
  endfunction

  // Returns byte number idx of a value.
  function automatic logic [7:0] byte_of(input logic [31:0] v, input int idx);
    return 8'(v >> (8 * idx));
  endfunction

endpackage

// File: rtl/pm_interval_timer.sv
module pm_interval_timer #(
  parameter int REF_PER_LONG  = 1544000,
  parameter int REF_PER_SHORT = 64848
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic short_sel,
  output logic boundary
);
  localparam int MAXP = (REF_PER_LONG > REF_PER_SHORT) ? REF_PER_LONG : REF_PER_SHORT;
  localparam int CW   = $clog2(MAXP + 1);
  localparam logic [CW-1:0] LIM_L = CW'(REF_PER_LONG - 1);
  localparam logic [CW-1:0] LIM_S = CW'(REF_PER_SHORT - 1);

  logic [CW-1:0] tcnt;
  logic [CW-1:0] lim;

  always_comb begin
    lim      = short_sel ? LIM_S : LIM_L;
    boundary = ref_tick && (tcnt >= lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tcnt <= '0;
    else if (boundary) tcnt <= '0;
    else if (ref_tick) tcnt <= tcnt + 1'b1;
  end

  AST_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |-> ref_tick); // R5
  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt < CW'(MAXP)); // R5
  AST_TIMER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(tcnt)); // R5

endmodule

// File: rtl/pm_sat_accum.sv
module pm_sat_accum #(
  parameter int W     = 16,
  parameter int INC_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     run_cnt,
  output logic [W-1:0]     hold_cnt
);
  import perfmon_pkg::*;

  localparam logic [31:0] MAXV = (32'd1 << W) - 32'd1;
  localparam logic [W-1:0] TOP = W'(MAXV);

  logic [W-1:0] run_next;
  logic [W-1:0] run_fresh;

  always_comb begin
    run_next  = W'(sat_add(32'(run_cnt), 32'(inc), MAXV));
    run_fresh = W'(sat_add(32'd0, 32'(inc), MAXV));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      hold_cnt <= '0;
    end else if (boundary) begin
      hold_cnt <= run_cnt;
      run_cnt  <= run_fresh;
    end else begin
      run_cnt  <= run_next;
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!boundary && run_cnt == TOP) |=> run_cnt == TOP); // R8
  AST_RUN_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> run_cnt >= $past(run_cnt)); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(hold_cnt)); // R6
  AST_HOLD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> hold_cnt == $past(run_cnt)); // R6
  AST_NEW_START: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && inc == '0) |=> run_cnt == '0); // R7

endmodule

// File: rtl/pm_host_regs.sv
module pm_host_regs #(
  parameter int CV_W  = 16,
  parameter int FE_W  = 12,
  parameter int OOS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  input  logic             reg_rd,
  input  logic             boundary,
  input  logic [CV_W-1:0]  cv_hold,
  input  logic [FE_W-1:0]  fe_hold,
  input  logic [OOS_W-1:0] oos_hold,
  output perfmon_pkg::ctrl_t ctrl,
  output logic             tick_flag,
  output logic             irq,
  output logic [7:0]       reg_rdata
);
  import perfmon_pkg::*;

  localparam int CTRL_W = $bits(ctrl_t);

  logic rd_status;
  logic wr_ctrl;

  always_comb begin
    rd_status = reg_rd && (reg_addr == A_STATUS);
    wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
    irq       = tick_flag & ctrl.tick_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (wr_ctrl) ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tick_flag <= 1'b0;
    else if (boundary)  tick_flag <= 1'b1;
    else if (rd_status) tick_flag <= 1'b0;
  end

  always_comb begin
    case (reg_addr)
      A_STATUS: reg_rdata = {7'd0, tick_flag};
      A_CTRL:   reg_rdata = 8'(ctrl);
      A_CV_HI:  reg_rdata = byte_of(32'(cv_hold), 1);
      A_CV_LO:  reg_rdata = byte_of(32'(cv_hold), 0);
      A_FE_HI:  reg_rdata = byte_of(32'(fe_hold), 1);
      A_FE_LO:  reg_rdata = byte_of(32'(fe_hold), 0);
      A_OOS:    reg_rdata = byte_of(32'(oos_hold), 0);
      default:  reg_rdata = 8'd0;
    endcase
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> tick_flag); // R10
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !boundary) |=> !tick_flag); // R10
  AST_FLAG_ROSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_flag) |-> $past(boundary)); // R10
  AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl)); // R9

endmodule

// File: rtl/t1_perf_counters.sv
module t1_perf_counters #(
  parameter int REF_PER_LONG  = 1544000,
  parameter int REF_PER_SHORT = 64848,
  parameter int CV_W          = 16,
  parameter int FE_W          = 12,
  parameter int OOS_W         = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       ev_bpv,
  input  logic       ev_exz,
  input  logic       ev_b8zs_cw,
  input  logic       rx_los,
  input  logic       ev_crc,
  input  logic       ev_fbit,
  input  logic       ev_mf_oos,
  input  logic [7:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  import perfmon_pkg::*;

  localparam logic [CV_W-1:0] CV_TOP = {CV_W{1'b1}};

  ctrl_t            ctrl;
  logic             boundary;
  logic             tick_flag;
  logic             cv_inc;
  logic [1:0]       fe_inc;
  logic             oos_inc;
  logic [CV_W-1:0]  cv_run, cv_hold;
  logic [FE_W-1:0]  fe_run, fe_hold;
  logic [OOS_W-1:0] oos_run, oos_hold;

  always_comb begin
    cv_inc  = viol_hit(ev_bpv, ev_exz, ev_b8zs_cw, ctrl.b8zs_rm);
    fe_inc  = {1'b0, ev_crc} + {1'b0, ev_fbit};
    oos_inc = ev_mf_oos;
  end

  pm_interval_timer #(
    .REF_PER_LONG (REF_PER_LONG),
    .REF_PER_SHORT(REF_PER_SHORT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .short_sel(ctrl.short_sel),
    .boundary (boundary)
  );

  pm_sat_accum #(.W(CV_W), .INC_W(1)) u_cv (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .inc(cv_inc),
    .run_cnt(cv_run), .hold_cnt(cv_hold)
  );

  pm_sat_accum #(.W(FE_W), .INC_W(2)) u_fe (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .inc(fe_inc),
    .run_cnt(fe_run), .hold_cnt(fe_hold)
  );

  pm_sat_accum #(.W(OOS_W), .INC_W(1)) u_oos (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .inc(oos_inc),
    .run_cnt(oos_run), .hold_cnt(oos_hold)
  );

  pm_host_regs #(.CV_W(CV_W), .FE_W(FE_W), .OOS_W(OOS_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rd   (reg_rd),
    .boundary (boundary),
    .cv_hold  (cv_hold),
    .fe_hold  (fe_hold),
    .oos_hold (oos_hold),
    .ctrl     (ctrl),
    .tick_flag(tick_flag),
    .irq      (irq),
    .reg_rdata(reg_rdata)
  );

  AST_CV_DURING_LOS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_los && (ev_bpv || ev_exz) && !(ctrl.b8zs_rm && ev_b8zs_cw) && !boundary
     && cv_run != CV_TOP) |=> cv_run == $past(cv_run) + 1'b1); // R2
  AST_CW_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.b8zs_rm && ev_b8zs_cw && !boundary) |=> cv_run == $past(cv_run)); // R1
  AST_FE_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_crc && ev_fbit && !boundary && fe_run < FE_W'(4000))
      |=> fe_run == $past(fe_run) + 2'd2); // R3
  AST_OOS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_mf_oos && !boundary) |=> $stable(oos_run)); // R4

endmodule

// File: tb/sim_t1_perf_counters.sv
module sim_t1_perf_counters;
  localparam int LONG  = 60;
  localparam int SHORT = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b1;
  logic ev_bpv = 0, ev_exz = 0, ev_b8zs_cw = 0, rx_los = 0;
  logic ev_crc = 0, ev_fbit = 0, ev_mf_oos = 0;
  logic [7:0] reg_addr = 8'h00;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq;

  int n_run = 0, n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  t1_perf_counters #(.REF_PER_LONG(LONG), .REF_PER_SHORT(SHORT)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .ev_bpv(ev_bpv), .ev_exz(ev_exz), .ev_b8zs_cw(ev_b8zs_cw), .rx_los(rx_los),
    .ev_crc(ev_crc), .ev_fbit(ev_fbit), .ev_mf_oos(ev_mf_oos),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk);
    reg_addr = 8'h21; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Clears the flag, then waits for the next interval end (irq rise).
  task automatic sync_tick();
    logic [7:0] d;
    bit seen = 0;
    rd(8'h20, d);
    for (int i = 0; i < 2000 && !seen; i++) begin
      if (irq) seen = 1;
      else @(negedge clk);
    end
    if (!seen) chk("R5 sync timeout", 0, 1);
  endtask

  task automatic pulse(input logic bpv, exz, cw, crc, fb, oos);
    ev_bpv = bpv; ev_exz = exz; ev_b8zs_cw = cw;
    ev_crc = crc; ev_fbit = fb; ev_mf_oos = oos;
    @(negedge clk);
    ev_bpv = 0; ev_exz = 0; ev_b8zs_cw = 0; ev_crc = 0; ev_fbit = 0; ev_mf_oos = 0;
  endtask

  task automatic read_counts(output int cv, output int fe, output int oos);
    logic [7:0] h, l;
    rd(8'h23, h); rd(8'h24, l); cv = {h, l};
    rd(8'h25, h); rd(8'h26, l); fe = {h, l};
    rd(8'h27, l); oos = l;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R12 irq after reset", irq, 0);
    for (int a = 8'h20; a <= 8'h27; a++) begin
      rd(8'(a), d);
      chk($sformatf("R12 reg %0h after reset", a), d, 0);
    end
    wr_ctrl(8'h05);
    rd(8'h21, d);
    chk("R9 ctrl readback", d, 5);
    rd(8'h22, d);
    chk("R9 unmapped reads zero", d, 0);
  endtask

  task automatic t_flag_mask();
    logic [7:0] d;
    bit seen = 0;
    wr_ctrl(8'h01);
    @(negedge clk);
    reg_addr = 8'h20;
    for (int i = 0; i < 500 && !seen; i++) begin
      @(negedge clk);
      #1 if (reg_rdata[0]) seen = 1;
    end
    chk("R10 flag set by interval end", seen, 1);
    chk("R11 irq masked", irq, 0);
    rd(8'h20, d);
    chk("R10 status read returns flag", d[0], 1);
    rd(8'h20, d);
    chk("R10 flag cleared by read", d[0], 0);
  endtask

  task automatic t_interval();
    int c1;
    wr_ctrl(8'h05);
    sync_tick(); c1 = cyc;
    chk("R11 irq with mask", irq, 1);
    sync_tick();
    chk("R5 short interval", cyc - c1, SHORT);
    wr_ctrl(8'h04);
    sync_tick(); sync_tick(); c1 = cyc;
    sync_tick();
    chk("R5 long interval", cyc - c1, LONG);
  endtask

  task automatic t_counts();
    int cv, fe, oos;
    sync_tick();
    repeat (5) pulse(1, 0, 0, 0, 0, 0);
    repeat (2) pulse(0, 1, 0, 0, 0, 0);
    pulse(1, 1, 0, 0, 0, 0);
    repeat (3) pulse(0, 0, 0, 1, 0, 0);
    repeat (2) pulse(0, 0, 0, 0, 1, 0);
    pulse(0, 0, 0, 1, 1, 0);
    repeat (4) pulse(0, 0, 0, 0, 0, 1);
    pulse(0, 0, 1, 0, 0, 0);
    sync_tick();
    read_counts(cv, fe, oos);
    chk("R1 violation count", cv, 8);
    chk("R3 crc/framing count", fe, 7);
    chk("R4 out-of-sync count", oos, 4);
    repeat (10) pulse(1, 0, 0, 0, 0, 0);
    read_counts(cv, fe, oos);
    chk("R6 holding stable mid-interval", cv, 8);
    sync_tick();
    read_counts(cv, fe, oos);
    chk("R6 next interval violations", cv, 10);
    chk("R6 next interval crc cleared", fe, 0);
  endtask

  task automatic t_b8zs();
    int cv, fe, oos;
    wr_ctrl(8'h06);
    sync_tick();
    repeat (3) pulse(1, 0, 1, 0, 0, 0);
    repeat (2) pulse(1, 0, 0, 0, 0, 0);
    pulse(0, 1, 0, 0, 0, 0);
    sync_tick();
    read_counts(cv, fe, oos);
    chk("R1 codewords removed", cv, 3);
    wr_ctrl(8'h04);
    sync_tick();
    rx_los = 1'b1;
    repeat (3) pulse(1, 0, 1, 0, 0, 0);
    repeat (2) pulse(1, 0, 0, 0, 0, 0);
    pulse(0, 1, 0, 0, 0, 0);
    rx_los = 1'b0;
    sync_tick();
    read_counts(cv, fe, oos);
    chk("R1 R2 codewords kept, los high", cv, 6);
  endtask

  task automatic t_edge();
    int cv, fe, oos;
    sync_tick();
    repeat (LONG - 2) @(negedge clk);
    ev_bpv = 1'b1;
    @(negedge clk);
    ev_mf_oos = 1'b1;
    @(negedge clk);
    ev_bpv = 1'b0; ev_mf_oos = 1'b0;
    chk("R10 flag on boundary", irq, 1);
    read_counts(cv, fe, oos);
    chk("R7 old interval violations", cv, 1);
    chk("R7 old interval oos", oos, 0);
    sync_tick();
    read_counts(cv, fe, oos);
    chk("R7 boundary violation in new", cv, 1);
    chk("R7 boundary oos in new", oos, 1);
  endtask

  task automatic t_sat();
    int cv, fe, oos;
    sync_tick();
    ref_tick = 1'b0;
    rx_los = 1'b1;
    ev_bpv = 1; ev_crc = 1; ev_fbit = 1; ev_mf_oos = 1;
    repeat (66000) @(negedge clk);
    ev_bpv = 0; ev_crc = 0; ev_fbit = 0; ev_mf_oos = 0;
    rx_los = 1'b0;
    ref_tick = 1'b1;
    sync_tick();
    read_counts(cv, fe, oos);
    chk("R8 R2 violation saturates", cv, 65535);
    chk("R8 crc saturates", fe, 4095);
    chk("R8 oos saturates", oos, 255);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_flag_mask();
    t_interval();
    t_counts();
    t_b8zs();
    t_edge();
    t_sat();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 4);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule